// File: doc/BRIEF.md
# Processor Sleep and Wakeup Controller

This block decides when a single processor core may stop its clock and when it may resume. The pipeline presents two kinds of sleep request from the memory stage. One is a wait-for-interrupt sleep. The other is a block sleep, which cores use to signal events to each other. The controller gates the core clock and can run a power-up request/acknowledge handshake for deep sleep. It raises a stall-release strobe in the cycle where the sleeping instruction may retire. While a sleep instruction is held, it also holds off interrupt entry.

Unblock events are sticky. A one-cycle unblock pulse from another core, or from this core looped back, sets a pending flag. A block request that finds the flag set completes at once, and completing a block consumes the flag. A wait-for-interrupt sleep leaves the flag alone. The block also produces this core's own outgoing unblock pulse when an unblock instruction passes the stage cleanly.

Top module: `core_sleep_ctrl`

## Requirements
- R1: During and after reset, `clk_en` and `pwrup_req` are 1 and `stall_release`, `irq_entry_hold` and `unblock_out` are 0. The sequencer is in its run state and no unblock is pending.
- R2: A 1 on `unblock_in` at a clock edge leaves an unblock pending. A later `sleep_block_req` then gets `stall_release` = 1 combinationally in the same cycle, and `clk_en` stays 1.
- R3: A block request that completes clears the pending unblock. A second block request with no new unblock goes to sleep: `clk_en` falls at the second clock edge after the request is raised, and it stays 0 while no wake event occurs.
- R4: A wait-for-interrupt sleep, including its wakeup, neither sets nor clears the pending unblock.
- R5: A sleeping block request wakes on an `unblock_in` pulse or on an interrupt wake. `clk_en` returns to 1 one edge after the wake cycle, and `stall_release` follows once `pwrup_ack` is 1.
- R6: An interrupt wake exists when some bit `i` has both `irq_pending[i]` and `irq_enable[i]` set. A pending bit whose enable is 0 does not wake. A wait-for-interrupt request that arrives while a wake already exists is released in the same cycle.
- R7: `clk_en` falls only after a clock edge at which `frontend_idle` was 1. While `frontend_idle` is 0, a sleep request keeps the clock running and the stall held.
- R8: When `allow_power_down` is 1 on entering sleep, `pwrup_req` falls together with `clk_en`. It returns to 1 on wake, and `stall_release` is withheld until `pwrup_ack` is 1. When `allow_power_down` is 0, `pwrup_req` stays 1.
- R9: `irq_entry_hold` is 1 exactly when a sleep request is present and `stall_release` is 0.
- R10: When `allow_block_sleep` is 0, a block request is released in the same cycle with the clock running. Any pending unblock is cleared as if the block had slept.
- R11: `unblock_out` is 1 for the cycle after an edge at which `unblock_instr` = 1, `unblock_except` = 0, `stage_bubble` = 0 and `stage_hold` = 0. Otherwise it is 0.
- R12: When `allow_sleep` is 0, a wait-for-interrupt request keeps the stall and the clock running until an interrupt wake appears. It is then released in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| allow_sleep | input | 1 | Wait-for-interrupt may gate the clock |
| allow_power_down | input | 1 | Sleep may drop the power-up request |
| allow_block_sleep | input | 1 | Block requests may gate the clock |
| frontend_idle | input | 1 | Fetch side is safe to stop |
| sleep_wfi_req | input | 1 | Wait-for-interrupt instruction held in memory stage |
| sleep_block_req | input | 1 | Block instruction held in memory stage |
| irq_pending | input | NUM_IRQ | Pending interrupt lines |
| irq_enable | input | NUM_IRQ | Per-line interrupt enables |
| unblock_in | input | 1 | One-cycle unblock event from any core |
| pwrup_ack | input | 1 | Power-up acknowledge |
| pwrup_req | output | 1 | Power-up request (low = may power down) |
| clk_en | output | 1 | Core clock enable |
| stall_release | output | 1 | Sleeping instruction may retire this cycle |
| irq_entry_hold | output | 1 | Hold off interrupt entry |
| unblock_instr | input | 1 | Unblock instruction in the stage |
| unblock_except | input | 1 | That instruction raised an exception |
| stage_bubble | input | 1 | A bubble replaces the instruction |
| stage_hold | input | 1 | The stage is stalled |
| unblock_out | output | 1 | Outgoing one-cycle unblock pulse |

## Verification
The hardest situation to reach is a deep-sleep wake. The power-up request must already have fallen, the environment must have dropped its acknowledge, and the wake event must arrive while the acknowledge is still low. The stimulus sleeps a block request with power-down allowed and lowers `pwrup_ack` after `pwrup_req` falls. It then wakes the core with an unblock pulse and keeps the acknowledge low for two cycles before raising it. The bench checks that release waits for the acknowledge, and that the unblock absorbed during the handshake leaves nothing pending.

// File: rtl/sleep_ctrl_pkg.sv
package sleep_ctrl_pkg;

    typedef enum logic [1:0] {
        SLP_RUN    = 2'd0,
        SLP_ENTER  = 2'd1,
        SLP_ASLEEP = 2'd2,
        SLP_WAKE   = 2'd3
    } slp_state_e;

    typedef struct packed {
        slp_state_e state;
        logic       kind_block;
        logic       clk_en;
        logic       pwrup_req;
    } slp_regs_t;

    localparam slp_regs_t SLP_RESET = '{state: SLP_RUN, kind_block: 1'b0,
                                        clk_en: 1'b1, pwrup_req: 1'b1};

endpackage

// File: rtl/sleep_unblock_latch.sv
module sleep_unblock_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic unblock_in,
    input  logic consume,
    output logic pending_q,
    output logic pending_now
);

    logic pending_d;

    always_comb begin
        pending_d = pending_q;
        if (consume)
            pending_d = 1'b0;
        else if (unblock_in)
            pending_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pending_q <= 1'b0;
        else
            pending_q <= pending_d;
    end

    assign pending_now = pending_q | unblock_in;

    // R2
    latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unblock_in && !consume) |=> pending_q);

    // R3
    latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        consume |=> !pending_q);

endmodule

// File: rtl/sleep_unblock_emit.sv
module sleep_unblock_emit (
    input  logic clk,
    input  logic rst_n,
    input  logic unblock_instr,
    input  logic unblock_except,
    input  logic stage_bubble,
    input  logic stage_hold,
    output logic unblock_out
);

    logic out_d, out_q;

    always_comb begin
        out_d = 1'b0;
        if (!stage_hold && !stage_bubble)
            out_d = unblock_instr && !unblock_except;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            out_q <= 1'b0;
        else
            out_q <= out_d;
    end

    assign unblock_out = out_q;

    // R11
    unblock_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_hold || stage_bubble || unblock_except || !unblock_instr) |=> !unblock_out);

endmodule

// File: rtl/sleep_power_fsm.sv
module sleep_power_fsm
    import sleep_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic allow_sleep,
    input  logic allow_power_down,
    input  logic allow_block_sleep,
    input  logic frontend_idle,
    input  logic wfi_req,
    input  logic block_req,
    input  logic irq_wake,
    input  logic unblock_pending,
    input  logic pwrup_ack,
    output logic clk_en,
    output logic pwrup_req,
    output logic stall_release,
    output logic consume_unblock
);

    slp_regs_t r_d, r_q;
    logic      wake_now;

    always_comb begin
        r_d             = r_q;
        stall_release   = 1'b0;
        consume_unblock = 1'b0;
        wake_now        = irq_wake || (r_q.kind_block && unblock_pending);

        unique case (r_q.state)
            SLP_RUN: begin
                if (block_req) begin
                    if (unblock_pending || irq_wake || !allow_block_sleep) begin
                        stall_release   = 1'b1;
                        consume_unblock = 1'b1;
                    end else begin
                        r_d.state      = SLP_ENTER;
                        r_d.kind_block = 1'b1;
                    end
                end else if (wfi_req) begin
                    if (irq_wake) begin
                        stall_release = 1'b1;
                    end else if (allow_sleep) begin
                        r_d.state      = SLP_ENTER;
                        r_d.kind_block = 1'b0;
                    end
                end
            end
            SLP_ENTER: begin
                if (wake_now) begin
                    stall_release   = 1'b1;
                    consume_unblock = r_q.kind_block;
                    r_d.state       = SLP_RUN;
                end else if (frontend_idle) begin
                    r_d.state     = SLP_ASLEEP;
                    r_d.clk_en    = 1'b0;
                    r_d.pwrup_req = !allow_power_down;
                end
            end
            SLP_ASLEEP: begin
                if (wake_now) begin
                    r_d.state     = SLP_WAKE;
                    r_d.clk_en    = 1'b1;
                    r_d.pwrup_req = 1'b1;
                end
            end
            SLP_WAKE: begin
                if (pwrup_ack) begin
                    stall_release   = 1'b1;
                    consume_unblock = r_q.kind_block;
                    r_d.state       = SLP_RUN;
                end
            end
            default: r_d = SLP_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r_q <= SLP_RESET;
        else
            r_q <= r_d;
    end

    assign clk_en    = r_q.clk_en;
    assign pwrup_req = r_q.pwrup_req;

    // R8
    release_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_release |-> pwrup_req);

    // R8
    pwrdn_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwrup_req) |-> !clk_en);

    // R7
    gate_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_en) |-> $past(frontend_idle));

    // R5
    asleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |-> !stall_release);

endmodule

// File: rtl/core_sleep_ctrl.sv
module core_sleep_ctrl #(
    parameter int NUM_IRQ = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               allow_sleep,
    input  logic               allow_power_down,
    input  logic               allow_block_sleep,
    input  logic               frontend_idle,
    input  logic               sleep_wfi_req,
    input  logic               sleep_block_req,
    input  logic [NUM_IRQ-1:0] irq_pending,
    input  logic [NUM_IRQ-1:0] irq_enable,
    input  logic               unblock_in,
    input  logic               pwrup_ack,
    output logic               pwrup_req,
    output logic               clk_en,
    output logic               stall_release,
    output logic               irq_entry_hold,
    input  logic               unblock_instr,
    input  logic               unblock_except,
    input  logic               stage_bubble,
    input  logic               stage_hold,
    output logic               unblock_out
);

    logic [NUM_IRQ-1:0] irq_live;
    logic irq_wake;
    logic pending_q, pending_now, consume;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
        assign irq_live[i] = irq_pending[i] & irq_enable[i];
    end
    assign irq_wake = |irq_live;

    sleep_unblock_latch u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .unblock_in  (unblock_in),
        .consume     (consume),
        .pending_q   (pending_q),
        .pending_now (pending_now)
    );

    sleep_power_fsm u_fsm (
        .clk               (clk),
        .rst_n             (rst_n),
        .allow_sleep       (allow_sleep),
        .allow_power_down  (allow_power_down),
        .allow_block_sleep (allow_block_sleep),
        .frontend_idle     (frontend_idle),
        .wfi_req           (sleep_wfi_req),
        .block_req         (sleep_block_req),
        .irq_wake          (irq_wake),
        .unblock_pending   (pending_now),
        .pwrup_ack         (pwrup_ack),
        .clk_en            (clk_en),
        .pwrup_req         (pwrup_req),
        .stall_release     (stall_release),
        .consume_unblock   (consume)
    );

    sleep_unblock_emit u_emit (
        .clk            (clk),
        .rst_n          (rst_n),
        .unblock_instr  (unblock_instr),
        .unblock_except (unblock_except),
        .stage_bubble   (stage_bubble),
        .stage_hold     (stage_hold),
        .unblock_out    (unblock_out)
    );

    assign irq_entry_hold = (sleep_wfi_req || sleep_block_req) && !stall_release;

    // R4
    wfi_keeps_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_wfi_req && !sleep_block_req && pending_q && stall_release) |=> pending_q);

endmodule

// File: tb/core_sleep_ctrl_test.sv
module core_sleep_ctrl_test;

    localparam int CLK_P = 10;
    localparam int NI    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic allow_sleep = 1'b1, allow_power_down = 1'b0, allow_block_sleep = 1'b1;
    logic frontend_idle = 1'b1, sleep_wfi_req = 1'b0, sleep_block_req = 1'b0;
    logic [NI-1:0] irq_pending = '0, irq_enable = '0;
    logic unblock_in = 1'b0, pwrup_ack = 1'b1;
    logic unblock_instr = 1'b0, unblock_except = 1'b0, stage_bubble = 1'b0, stage_hold = 1'b0;
    logic pwrup_req, clk_en, stall_release, irq_entry_hold, unblock_out;

    int checks = 0;
    int errors = 0;

    // {instr, except, bubble, hold, expected unblock_out after the edge}
    localparam logic [4:0] VEC [8] = '{
        5'b1000_1, 5'b1100_0, 5'b1010_0, 5'b1001_0,
        5'b0000_0, 5'b1000_1, 5'b1000_1, 5'b0001_0
    };

    core_sleep_ctrl #(.NUM_IRQ(NI)) uut (
        .clk(clk), .rst_n(rst_n),
        .allow_sleep(allow_sleep), .allow_power_down(allow_power_down),
        .allow_block_sleep(allow_block_sleep), .frontend_idle(frontend_idle),
        .sleep_wfi_req(sleep_wfi_req), .sleep_block_req(sleep_block_req),
        .irq_pending(irq_pending), .irq_enable(irq_enable),
        .unblock_in(unblock_in), .pwrup_ack(pwrup_ack),
        .pwrup_req(pwrup_req), .clk_en(clk_en), .stall_release(stall_release),
        .irq_entry_hold(irq_entry_hold),
        .unblock_instr(unblock_instr), .unblock_except(unblock_except),
        .stage_bubble(stage_bubble), .stage_hold(stage_hold),
        .unblock_out(unblock_out)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic pulse_unblock();
        unblock_in = 1'b1;
        tick();
        unblock_in = 1'b0;
    endtask

    initial begin
        #(CLK_P * 50000);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(); tick();
        // R1 reset state
        chk("R1 clk_en", clk_en, 1);
        chk("R1 pwrup_req", pwrup_req, 1);
        chk("R1 stall_release", stall_release, 0);
        chk("R1 unblock_out", unblock_out, 0);
        chk("R1 irq_entry_hold", irq_entry_hold, 0);
        rst_n = 1'b1;
        tick();

        // R11 vector table
        foreach (VEC[i]) begin
            {unblock_instr, unblock_except, stage_bubble, stage_hold} = VEC[i][4:1];
            tick();
            chk($sformatf("R11 vec%0d", i), unblock_out, VEC[i][0]);
        end
        {unblock_instr, unblock_except, stage_bubble, stage_hold} = 4'b0;
        tick();

        // R2 early unblock makes block complete at once
        pulse_unblock();
        sleep_block_req = 1'b1;
        settle();
        chk("R2 stall_release", stall_release, 1);
        chk("R2 clk_en", clk_en, 1);
        tick();
        sleep_block_req = 1'b0;

        // R3 second block sleeps; R5 wake by unblock
        sleep_block_req = 1'b1;
        settle();
        chk("R3 no release", stall_release, 0);
        chk("R9 hold while stalled", irq_entry_hold, 1);
        tick(); tick(); settle();
        chk("R3 clk gated", clk_en, 0);
        chk("R8 no power-down keeps req", pwrup_req, 1);
        tick(); tick(); settle();
        chk("R3 stays asleep", clk_en, 0);
        unblock_in = 1'b1;
        settle();
        chk("R5 no release in wake cycle", stall_release, 0);
        tick();
        unblock_in = 1'b0;
        settle();
        chk("R5 clk_en back", clk_en, 1);
        chk("R5 release after unblock", stall_release, 1);
        chk("R9 no hold on release", irq_entry_hold, 0);
        tick();
        sleep_block_req = 1'b0;

        // R6 block times out on an enabled interrupt only
        sleep_block_req = 1'b1;
        tick(); tick(); settle();
        chk("R3 block sleeps again", clk_en, 0);
        irq_pending = 4'b0001;
        tick(); tick(); settle();
        chk("R6 disabled irq no wake", clk_en, 0);
        irq_enable = 4'b0001;
        tick(); settle();
        chk("R5 clk_en on irq wake", clk_en, 1);
        chk("R5 release on irq wake", stall_release, 1);
        tick();
        sleep_block_req = 1'b0; irq_pending = '0; irq_enable = '0;

        // R4 WFI sleep keeps pending unblock
        pulse_unblock();
        sleep_wfi_req = 1'b1;
        tick(); tick(); settle();
        chk("R4 wfi sleeps", clk_en, 0);
        irq_pending = 4'b0100; irq_enable = 4'b0100;
        tick(); settle();
        chk("R4 wfi released", stall_release, 1);
        tick();
        sleep_wfi_req = 1'b0; irq_pending = '0; irq_enable = '0;
        sleep_block_req = 1'b1;
        settle();
        chk("R4 latch survived wfi", stall_release, 1);
        tick();
        sleep_block_req = 1'b0;

        // R6 wfi with wake already present
        irq_pending = 4'b0010; irq_enable = 4'b0010;
        sleep_wfi_req = 1'b1;
        settle();
        chk("R6 immediate wfi release", stall_release, 1);
        tick();
        sleep_wfi_req = 1'b0; irq_pending = '0; irq_enable = '0;

        // R7 frontend busy keeps clock running
        frontend_idle = 1'b0;
        sleep_wfi_req = 1'b1;
        tick(); tick(); tick(); settle();
        chk("R7 clk runs while busy", clk_en, 1);
        chk("R7 stall held", stall_release, 0);
        frontend_idle = 1'b1;
        tick(); settle();
        chk("R7 gated after idle", clk_en, 0);
        irq_pending = 4'b1000; irq_enable = 4'b1000;
        tick(); settle();
        chk("R7 wake release", stall_release, 1);
        tick();
        sleep_wfi_req = 1'b0; irq_pending = '0; irq_enable = '0;

        // R8 power-down handshake
        allow_power_down = 1'b1;
        sleep_block_req = 1'b1;
        tick(); tick(); settle();
        chk("R8 clk gated", clk_en, 0);
        chk("R8 pwrup_req low", pwrup_req, 0);
        pwrup_ack = 1'b0;
        tick();
        unblock_in = 1'b1;
        tick();
        unblock_in = 1'b0;
        settle();
        chk("R8 pwrup_req raised", pwrup_req, 1);
        chk("R8 wait for ack", stall_release, 0);
        tick(); settle();
        chk("R8 still waiting", stall_release, 0);
        pwrup_ack = 1'b1;
        settle();
        chk("R8 release on ack", stall_release, 1);
        tick();
        sleep_block_req = 1'b0; allow_power_down = 1'b0;
        sleep_block_req = 1'b1;
        settle();
        chk("R8 handshake unblock consumed", stall_release, 0);
        tick(); tick();
        irq_pending = 4'b0001; irq_enable = 4'b0001;
        tick(); settle();
        chk("R5 wake after consumed", stall_release, 1);
        tick();
        sleep_block_req = 1'b0; irq_pending = '0; irq_enable = '0;

        // R10 block not allowed
        pulse_unblock();
        allow_block_sleep = 1'b0;
        sleep_block_req = 1'b1;
        settle();
        chk("R10 immediate release", stall_release, 1);
        chk("R10 clk runs", clk_en, 1);
        tick();
        sleep_block_req = 1'b0;
        allow_block_sleep = 1'b1;
        sleep_block_req = 1'b1;
        settle();
        chk("R10 latch cleared", stall_release, 0);
        tick(); tick(); settle();
        chk("R10 next block sleeps", clk_en, 0);
        irq_pending = 4'b0001; irq_enable = 4'b0001;
        tick(); settle();
        chk("R10 wake release", stall_release, 1);
        tick();
        sleep_block_req = 1'b0; irq_pending = '0; irq_enable = '0;

        // R12 wfi with sleep disallowed
        allow_sleep = 1'b0;
        sleep_wfi_req = 1'b1;
        tick(); tick(); tick(); settle();
        chk("R12 clk runs", clk_en, 1);
        chk("R12 stall held", stall_release, 0);
        chk("R9 hold asserted", irq_entry_hold, 1);
        irq_pending = 4'b0100; irq_enable = 4'b0100;
        settle();
        chk("R12 release on wake", stall_release, 1);
        chk("R9 hold dropped", irq_entry_hold, 0);
        tick();
        sleep_wfi_req = 1'b0; irq_pending = '0; irq_enable = '0; allow_sleep = 1'b1;
        tick();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule